// File: doc/BRIEF.md
# Shadowed SRAM with Nonvolatile Backup

This block is a 64-word by 4-bit static RAM. Each RAM bit has a matching shadow bit that stands in for nonvolatile storage. Ordinary reads and writes reach only the RAM. Two active-low strobes move the whole array in bulk:

- **Store** copies the RAM into the shadow array.
- **Recall** copies the shadow array back into the RAM.

A falling strobe starts a transfer. The transfer then runs for a fixed number of clock cycles set by a parameter, and a busy flag stays high for that whole time.

The data bus is split into an input word, an output word and an output-enable, so a pad ring can build the tri-state pin from them. A supply-good input models the low-voltage detector: while it is low, store requests are refused. When both strobes fall together, recall wins. Reset clears the RAM and the sequencer but leaves the shadow array alone. A recall after a power cycle therefore brings back the last completed store.

Top module: `nvsram_top`

## Requirements
- R1: During and after synchronous reset (`rst` high), every RAM word reads 0, `busy` is low and `dout_oe` is low until a read is requested.
- R2: With `cs_n` high and both strobes high, `dout_oe` is low (standby).
- R3: With `cs_n` low, `we_n` high, both strobes high and `busy` low, `dout_oe` is high and `dout` shows the word at `addr` in the same cycle.
- R4: With `cs_n` low, `we_n` low, both strobes high and `busy` low, `din` is written into the word at `addr` at the clock edge.
- R5: A falling `rcl_n` seen while `busy` is low and (`we_n` high or `cs_n` high) starts a recall. `busy` is then high for exactly `RECALL_CYC` cycles, and on the edge where `busy` drops, every RAM word takes its shadow value.
- R6: A falling `sto_n` seen while `busy` is low, `rcl_n` is high, `pwr_ok` is high and (`we_n` high or `cs_n` high) starts a store. `busy` is then high for exactly `STORE_CYC` cycles, and on the edge where `busy` drops, every shadow word takes its RAM value.
- R7: If both strobes fall in the same cycle, a recall starts and the store is discarded. A store strobe that falls while `rcl_n` is held low starts nothing.
- R8: A store strobe that falls while `pwr_ok` is low starts nothing: `busy` stays low and the shadow array keeps its contents.
- R9: While `busy` is high, `dout_oe` is low, writes are ignored and new strobe edges are ignored. `busy` stays high until its counter expires.
- R10: Reset leaves the shadow array unchanged. A store cut short by reset does not modify the shadow array.
- R11: Transfers start only on a falling strobe edge. A strobe held low after its transfer finishes does not start another one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| rcl_n | input | 1 | Recall strobe, active low, acts on its falling edge |
| sto_n | input | 1 | Store strobe, active low, acts on its falling edge |
| pwr_ok | input | 1 | High when the supply is above the safe store threshold |
| addr | input | 6 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data |
| dout_oe | output | 1 | High when `dout` should drive the bus |
| busy | output | 1 | High while a store or recall is in progress |

## Verification
The embedded assertions check the following on every cycle:
- the output is never driven in standby or while busy;
- a write lands in the addressed word on the next edge;
- busy cannot drop before its counter expires;
- recall wins over a simultaneous store;
- a store strobe under low supply leaves the block idle.

Other properties depend on hidden shadow contents, so only the bench scenarios can show them, by recalling and then reading back:
- that a store and a recall actually move the data;
- that a refused store leaves the shadow array untouched;
- that a write attempted while busy leaves its word unchanged;
- that an aborted store and a reset keep the old backup;
- the exact busy lengths.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_STORE  = 2'd1,
        XF_RECALL = 2'd2
    } xfer_e;
endpackage

// File: rtl/nvs_mode_dec.sv
module nvs_mode_dec (
    input  logic cs_n,
    input  logic we_n,
    input  logic rcl_n,
    input  logic sto_n,
    input  logic busy,
    output logic rd_en,
    output logic wr_en,
    output logic xfer_ok
);
    logic strobes_idle;

    always_comb begin
        strobes_idle = rcl_n && sto_n;
        rd_en        = !cs_n && we_n && strobes_idle && !busy;
        wr_en        = !cs_n && !we_n && strobes_idle && !busy;
        // a transfer may not begin in the middle of an active write cycle
        xfer_ok      = we_n || cs_n;
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvsram_pkg::*;
#(
    parameter int STORE_CYC  = 1250000,
    parameter int RECALL_CYC = 188
) (
    input  logic clk,
    input  logic rst,
    input  logic rcl_n,
    input  logic sto_n,
    input  logic pwr_ok,
    input  logic xfer_ok,
    output logic busy,
    output logic copy_sto,
    output logic copy_rcl
);
    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        xfer_e            kind;
        logic [CNT_W-1:0] cnt;
        logic             rcl_prev;
        logic             sto_prev;
    } seq_t;

    seq_t st_d, st_q;
    logic rcl_fall, sto_fall, done;

    always_comb begin
        st_d          = st_q;
        st_d.rcl_prev = rcl_n;
        st_d.sto_prev = sto_n;
        rcl_fall      = st_q.rcl_prev && !rcl_n;
        sto_fall      = st_q.sto_prev && !sto_n;
        busy          = (st_q.kind != XF_IDLE);
        done          = busy && (st_q.cnt == '0);
        copy_sto      = done && (st_q.kind == XF_STORE);
        copy_rcl      = done && (st_q.kind == XF_RECALL);
        if (busy) begin
            if (done) st_d.kind = XF_IDLE;
            else      st_d.cnt  = st_q.cnt - 1'b1;
        end else if (rcl_fall && xfer_ok) begin
            st_d.kind = XF_RECALL;
            st_d.cnt  = CNT_W'(RECALL_CYC - 1);
        end else if (sto_fall && rcl_n && pwr_ok && xfer_ok) begin
            st_d.kind = XF_STORE;
            st_d.cnt  = CNT_W'(STORE_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.kind     <= XF_IDLE;
            st_q.cnt      <= '0;
            st_q.rcl_prev <= 1'b1;
            st_q.sto_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_hold_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && st_q.cnt != '0) |=> busy);

    assert_recall_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && rcl_fall && sto_fall && xfer_ok) |=> (st_q.kind == XF_RECALL));

    assert_low_supply_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && sto_fall && rcl_n && !pwr_ok) |=> !busy);
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en,
    input  logic              copy_sto,
    input  logic              copy_rcl,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram_d    [DEPTH];
    logic [DATA_W-1:0] ram_q    [DEPTH];
    logic [DATA_W-1:0] shadow_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_comb begin
            ram_d[w] = ram_q[w];
            if (copy_rcl)
                ram_d[w] = shadow_q[w];
            else if (wr_en && addr == ADDR_W'(w))
                ram_d[w] = din;
        end

        always_ff @(posedge clk) begin
            if (rst) ram_q[w] <= '0;
            else     ram_q[w] <= ram_d[w];
        end

        // the shadow cell has no reset: it models the backup that outlives power loss
        always_ff @(posedge clk) begin
            if (copy_sto && !rst) shadow_q[w] <= ram_q[w];
        end
    end

    assign dout = ram_q[addr];

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ram_q[$past(addr)] == $past(din)));
endmodule

// File: rtl/nvsram_top.sv
module nvsram_top #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 4,
    parameter int STORE_CYC  = 1250000,
    parameter int RECALL_CYC = 188
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              rcl_n,
    input  logic              sto_n,
    input  logic              pwr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);
    logic rd_en, wr_en, xfer_ok, copy_sto, copy_rcl;

    nvs_mode_dec u_dec (
        .cs_n    (cs_n),
        .we_n    (we_n),
        .rcl_n   (rcl_n),
        .sto_n   (sto_n),
        .busy    (busy),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .xfer_ok (xfer_ok)
    );

    nvs_seq #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rcl_n    (rcl_n),
        .sto_n    (sto_n),
        .pwr_ok   (pwr_ok),
        .xfer_ok  (xfer_ok),
        .busy     (busy),
        .copy_sto (copy_sto),
        .copy_rcl (copy_rcl)
    );

    nvs_arrays #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .din      (din),
        .wr_en    (wr_en),
        .copy_sto (copy_sto),
        .copy_rcl (copy_rcl),
        .dout     (dout)
    );

    assign dout_oe = rd_en;

    assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dout_oe);

    assert_standby_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && rcl_n && sto_n) |-> !dout_oe);
endmodule

// File: tb/tb_nvsram_top.sv
`timescale 1ns/1ps
module tb_nvsram_top;
    localparam int SCYC = 40;
    localparam int RCYC = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, we_n = 1'b1, rcl_n = 1'b1, sto_n = 1'b1, pwr_ok = 1'b1;
    logic [5:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_oe, busy;

    nvsram_top #(.STORE_CYC(SCYC), .RECALL_CYC(RCYC)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .rcl_n(rcl_n),
        .sto_n(sto_n), .pwr_ok(pwr_ok), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy)
    );

    always #4 clk = ~clk;

    typedef struct {
        int         a;
        logic [3:0] d;
        bit         oe;
        string      req;
    } item_t;

    item_t      sb[$];
    logic [3:0] exp_ram [64];
    logic [3:0] exp_sh  [64];
    int         n_run = 0;
    int         n_fail = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: compares one queued read item per cycle, shortly after the edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(dout_oe == it.oe, it.req, "dout_oe", int'(dout_oe), int'(it.oe));
            if (it.oe)
                chk(dout == it.d, it.req, $sformatf("dout @%0d", it.a), int'(dout), int'(it.d));
        end
    end

    task automatic idle();
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(int a, logic [3:0] d);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = 6'(a); din = d;
        exp_ram[a] = d;
    endtask

    task automatic rd(int a, bit oe, string req);
        item_t it;
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b1; addr = 6'(a);
        it.a = a; it.d = exp_ram[a]; it.oe = oe; it.req = req;
        sb.push_back(it);
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < 64; a++) rd(a, 1'b1, req);
        idle();
    endtask

    // sample busy after successive edges and count how many cycles it stays high
    task automatic count_busy(output int n);
        n = 0;
        forever begin
            @(posedge clk); #2;
            if (busy && n < 100000) n++;
            else break;
        end
    endtask

    // kind: 0 recall, 1 store, 2 both together
    task automatic xfer(int kind, int expc, string req);
        int n;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        if (kind != 1) rcl_n = 1'b0;
        if (kind != 0) sto_n = 1'b0;
        count_busy(n);
        chk(n == expc, req, "busy cycles", n, expc);
        @(negedge clk);
        rcl_n = 1'b1; sto_n = 1'b1;
    endtask

    function automatic logic [3:0] pat(int sel, int a);
        case (sel)
            1: return 4'((a * 5 + 3) & 15);
            2: return ~4'((a * 5 + 3) & 15);
            3: return 4'(a) ^ 4'h9;
            default: return ~(4'(a) ^ 4'h9);
        endcase
    endfunction

    task automatic fill(int sel);
        for (int a = 0; a < 64; a++) wr(a, pat(sel, a));
        idle();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < 64; a++) exp_ram[a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(dout_oe == 1'b0, "R1", "dout_oe after reset", int'(dout_oe), 0);
        read_all("R1");

        // R2 standby
        @(negedge clk); cs_n = 1'b1; we_n = 1'b1; addr = 6'd7;
        @(posedge clk); #2;
        chk(dout_oe == 1'b0, "R2", "standby dout_oe", int'(dout_oe), 0);

        // R3, R4 write then read back
        fill(1);
        read_all("R3_R4");

        // R8 store refused under low supply
        pwr_ok = 1'b0;
        xfer(1, 0, "R8");
        pwr_ok = 1'b1;

        // R6 full store, R9 write during busy ignored
        @(negedge clk); cs_n = 1'b1; we_n = 1'b1; sto_n = 1'b0;
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; addr = 6'd5; din = ~exp_ram[5];
        @(negedge clk); we_n = 1'b1;
        rcl_n = 1'b0;  // new strobe edge during busy must be ignored
        begin
            item_t it;
            it.a = 5; it.d = '0; it.oe = 1'b0; it.req = "R9";
            sb.push_back(it);
        end
        count_busy(n);
        chk(n == SCYC - 2, "R6", "store busy remaining", n, SCYC - 2);
        exp_sh = exp_ram;
        @(negedge clk); sto_n = 1'b1; rcl_n = 1'b1; cs_n = 1'b1;
        @(posedge clk); #2;
        chk(busy == 1'b0, "R9", "no recall from strobe seen while busy", int'(busy), 0);
        rd(5, 1'b1, "R9");
        idle();

        // R5 recall restores shadow
        fill(2);
        xfer(0, RCYC, "R5");
        exp_ram = exp_sh;
        read_all("R5_R6");

        // R8 at ports: shadow untouched by refused store
        fill(2);
        pwr_ok = 1'b0;
        xfer(1, 0, "R8");
        pwr_ok = 1'b1;
        xfer(0, RCYC, "R8");
        exp_ram = exp_sh;
        read_all("R8");

        // R7 priority: both strobes together
        fill(3);
        xfer(2, RCYC, "R7");
        exp_ram = exp_sh;
        read_all("R7");

        // R7 store under held recall, R11 no retrigger while held
        @(negedge clk); rcl_n = 1'b0;
        count_busy(n);
        chk(n == RCYC, "R11", "recall busy", n, RCYC);
        @(negedge clk); sto_n = 1'b0;
        count_busy(n);
        chk(n == 0, "R7", "store under recall low", n, 0);
        repeat (4) begin
            @(posedge clk); #2;
            chk(busy == 1'b0, "R11", "held strobe retrigger", int'(busy), 0);
        end
        @(negedge clk); rcl_n = 1'b1; sto_n = 1'b1;

        // R10 store aborted by reset keeps old backup
        fill(3);
        xfer(1, SCYC, "R6");
        exp_sh = exp_ram;
        fill(4);
        @(negedge clk); sto_n = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1; sto_n = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int a = 0; a < 64; a++) exp_ram[a] = '0;
        @(posedge clk); #2;
        chk(busy == 1'b0, "R10", "busy after abort", int'(busy), 0);
        read_all("R1");
        xfer(0, RCYC, "R10");
        exp_ram = exp_sh;
        read_all("R10");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule